// File: doc/BRIEF.md
# Mode-Driven Audio Routing Mixer

This block routes three incoming sample streams (a voice channel and a stereo audio pair) to three playback outputs: a mono speaker feed and the two headphone channels. A 4-bit operating mode selects, for each output, one of six sources. The sources are silence, voice, left audio, right audio, a left-plus-right mix, or a voice-plus-left mix. Summed sources clamp to the signed sample range instead of wrapping.

Every output also carries an enable flag, which power management uses to switch off idle output paths. The mode input is read only when the sample strobe fires. A mode change therefore never splits a sample period and cannot cause an audible glitch. Outputs, valid pulses and enables are registered and appear one clock after the strobe.

Top module: `audio_route_mixer`

## Requirements
- R1: While reset is asserted, and until the first strobe after reset, all three sample outputs are zero and all enable and valid flags are low.
- R2: Mode codes 0 (powerdown) and 1 (standby) leave every output without a source.
- R3: Mode 2 routes voice to the speaker only. Mode 3 routes voice to both headphone channels only. Mode 4 routes voice to all three outputs.
- R4: Mode 5 routes left+right to the speaker only. Mode 6 routes left audio to headphone left and right audio to headphone right. Mode 7 applies both of those routings together.
- R5: Mode 8 routes left audio to the speaker and voice to both headphones. Mode 9 routes voice+left to the speaker and voice to both headphones. Mode 10 routes voice to the speaker and left audio to both headphones.
- R6: Mode codes 11 through 15 behave exactly like powerdown.
- R7: Summed sources add the two signed 16-bit samples without scaling and clamp the result to the range -32768 to 32767.
- R8: The mode input and sample inputs are taken only in a cycle where the strobe is high. Between strobes, a changed mode leaves outputs and enables unchanged.
- R9: The samples and enables that a strobe selects appear in the clock after that strobe. Each valid flag is then high for exactly that one cycle, and only on outputs that have a source.
- R10: An output with no source drives a zero sample and holds its enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Operating mode code |
| strobe_i | input | 1 | Sample boundary strobe |
| voice_i | input | 16 | Signed voice sample |
| left_i | input | 16 | Signed left audio sample |
| right_i | input | 16 | Signed right audio sample |
| spk_o | output | 16 | Mono speaker sample |
| spk_valid_o | output | 1 | Speaker sample valid pulse |
| spk_en_o | output | 1 | Speaker path enable |
| hpl_o | output | 16 | Headphone left sample |
| hpl_valid_o | output | 1 | Headphone left valid pulse |
| hpl_en_o | output | 1 | Headphone left enable |
| hpr_o | output | 16 | Headphone right sample |
| hpr_valid_o | output | 1 | Headphone right valid pulse |
| hpr_en_o | output | 1 | Headphone right enable |

## Verification
The bench builds the block with its default widths: 16-bit samples and a 4-bit mode. With these widths it can sweep every one of the sixteen mode codes, reserved ones included, and compare each output against a table it keeps itself. The full 16-bit range also lets it drive the clamp limits exactly, in both directions, for both kinds of summed source. Separate scenarios change the mode between strobes and check that the valid flag is a single pulse.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int NUM_OUT = 3;
  localparam int OUT_SPK = 0;
  localparam int OUT_HPL = 1;
  localparam int OUT_HPR = 2;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_VOICE = 3'd1,
    SRC_LEFT  = 3'd2,
    SRC_RIGHT = 3'd3,
    SRC_LR    = 3'd4,
    SRC_VL    = 3'd5
  } src_e;
endpackage

// File: rtl/route_rst_sync.sv
module route_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/route_mode_decode.sv
module route_mode_decode
  import route_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic [MODE_W-1:0] mode_i,
  output src_e              src_o [NUM_OUT]
);
  always_comb begin
    src_o[OUT_SPK] = SRC_NONE;
    src_o[OUT_HPL] = SRC_NONE;
    src_o[OUT_HPR] = SRC_NONE;
    case (mode_i)
      MODE_W'(2): src_o[OUT_SPK] = SRC_VOICE;
      MODE_W'(3): begin
        src_o[OUT_HPL] = SRC_VOICE;
        src_o[OUT_HPR] = SRC_VOICE;
      end
      MODE_W'(4): begin
        src_o[OUT_SPK] = SRC_VOICE;
        src_o[OUT_HPL] = SRC_VOICE;
        src_o[OUT_HPR] = SRC_VOICE;
      end
      MODE_W'(5): src_o[OUT_SPK] = SRC_LR;
      MODE_W'(6): begin
        src_o[OUT_HPL] = SRC_LEFT;
        src_o[OUT_HPR] = SRC_RIGHT;
      end
      MODE_W'(7): begin
        src_o[OUT_SPK] = SRC_LR;
        src_o[OUT_HPL] = SRC_LEFT;
        src_o[OUT_HPR] = SRC_RIGHT;
      end
      MODE_W'(8): begin
        src_o[OUT_SPK] = SRC_LEFT;
        src_o[OUT_HPL] = SRC_VOICE;
        src_o[OUT_HPR] = SRC_VOICE;
      end
      MODE_W'(9): begin
        src_o[OUT_SPK] = SRC_VL;
        src_o[OUT_HPL] = SRC_VOICE;
        src_o[OUT_HPR] = SRC_VOICE;
      end
      MODE_W'(10): begin
        src_o[OUT_SPK] = SRC_VOICE;
        src_o[OUT_HPL] = SRC_LEFT;
        src_o[OUT_HPR] = SRC_LEFT;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/route_sat_add.sv
module route_sat_add #(
  parameter int SAMPLE_W = 16
) (
  input  logic signed [SAMPLE_W-1:0] a_i,
  input  logic signed [SAMPLE_W-1:0] b_i,
  output logic signed [SAMPLE_W-1:0] sum_o
);
  localparam logic signed [SAMPLE_W-1:0] MAX_V = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SAMPLE_W-1:0] MIN_V = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W:0] wide;

  always_comb begin
    wide = {a_i[SAMPLE_W-1], a_i} + {b_i[SAMPLE_W-1], b_i};
    if (wide[SAMPLE_W] != wide[SAMPLE_W-1]) begin
      sum_o = wide[SAMPLE_W] ? MIN_V : MAX_V;
    end else begin
      sum_o = wide[SAMPLE_W-1:0];
    end
  end
endmodule

// File: rtl/route_channel.sv
module route_channel
  import route_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       strobe_i,
  input  src_e                       src_i,
  input  logic signed [SAMPLE_W-1:0] voice_i,
  input  logic signed [SAMPLE_W-1:0] left_i,
  input  logic signed [SAMPLE_W-1:0] right_i,
  input  logic signed [SAMPLE_W-1:0] lr_sum_i,
  input  logic signed [SAMPLE_W-1:0] vl_sum_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       valid_o,
  output logic                       en_o
);
  logic signed [SAMPLE_W-1:0] pick;
  logic signed [SAMPLE_W-1:0] sample_d, sample_q;
  logic                       en_d, en_q;
  logic                       valid_d, valid_q;
  logic                       has_src;

  always_comb begin
    case (src_i)
      SRC_VOICE: pick = voice_i;
      SRC_LEFT:  pick = left_i;
      SRC_RIGHT: pick = right_i;
      SRC_LR:    pick = lr_sum_i;
      SRC_VL:    pick = vl_sum_i;
      default:   pick = '0;
    endcase
    has_src  = (src_i != SRC_NONE);
    sample_d = sample_q;
    en_d     = en_q;
    valid_d  = 1'b0;
    if (strobe_i) begin
      sample_d = pick;
      en_d     = has_src;
      valid_d  = has_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      en_q     <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      sample_q <= sample_d;
      en_q     <= en_d;
      valid_q  <= valid_d;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;
  assign en_o     = en_q;
endmodule

// File: rtl/audio_route_mixer.sv
module audio_route_mixer
  import route_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int MODE_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [MODE_W-1:0]          mode_i,
  input  logic                       strobe_i,
  input  logic signed [SAMPLE_W-1:0] voice_i,
  input  logic signed [SAMPLE_W-1:0] left_i,
  input  logic signed [SAMPLE_W-1:0] right_i,
  output logic signed [SAMPLE_W-1:0] spk_o,
  output logic                       spk_valid_o,
  output logic                       spk_en_o,
  output logic signed [SAMPLE_W-1:0] hpl_o,
  output logic                       hpl_valid_o,
  output logic                       hpl_en_o,
  output logic signed [SAMPLE_W-1:0] hpr_o,
  output logic                       hpr_valid_o,
  output logic                       hpr_en_o
);
  logic                       rst_sync_n;
  src_e                       route [NUM_OUT];
  logic signed [SAMPLE_W-1:0] lr_sum, vl_sum;
  logic signed [SAMPLE_W-1:0] smp   [NUM_OUT];
  logic                       vld   [NUM_OUT];
  logic                       ena   [NUM_OUT];

  route_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  route_mode_decode #(.MODE_W(MODE_W)) u_dec (
    .mode_i(mode_i),
    .src_o (route)
  );

  route_sat_add #(.SAMPLE_W(SAMPLE_W)) u_add_lr (
    .a_i  (left_i),
    .b_i  (right_i),
    .sum_o(lr_sum)
  );

  route_sat_add #(.SAMPLE_W(SAMPLE_W)) u_add_vl (
    .a_i  (voice_i),
    .b_i  (left_i),
    .sum_o(vl_sum)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    route_channel #(.SAMPLE_W(SAMPLE_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .strobe_i(strobe_i),
      .src_i   (route[g]),
      .voice_i (voice_i),
      .left_i  (left_i),
      .right_i (right_i),
      .lr_sum_i(lr_sum),
      .vl_sum_i(vl_sum),
      .sample_o(smp[g]),
      .valid_o (vld[g]),
      .en_o    (ena[g])
    );
  end

  assign spk_o       = smp[OUT_SPK];
  assign spk_valid_o = vld[OUT_SPK];
  assign spk_en_o    = ena[OUT_SPK];
  assign hpl_o       = smp[OUT_HPL];
  assign hpl_valid_o = vld[OUT_HPL];
  assign hpl_en_o    = ena[OUT_HPL];
  assign hpr_o       = smp[OUT_HPR];
  assign hpr_valid_o = vld[OUT_HPR];
  assign hpr_en_o    = ena[OUT_HPR];
endmodule

// File: rtl/route_mixer_checker.sv
module route_mixer_checker #(
  parameter int SAMPLE_W = 16,
  parameter int MODE_W   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [MODE_W-1:0]   mode_i,
  input logic                strobe_i,
  input logic [SAMPLE_W-1:0] spk_o,
  input logic                spk_valid_o,
  input logic                spk_en_o,
  input logic [SAMPLE_W-1:0] hpl_o,
  input logic                hpl_valid_o,
  input logic                hpl_en_o,
  input logic [SAMPLE_W-1:0] hpr_o,
  input logic                hpr_valid_o,
  input logic                hpr_en_o
);
  logic quiet_mode;
  assign quiet_mode = (mode_i < MODE_W'(2)) || (mode_i > MODE_W'(10));

  // R9: a valid pulse always follows a strobe
  a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (spk_valid_o || hpl_valid_o || hpr_valid_o) |-> $past(strobe_i));

  // R9: valid only on outputs with a source
  a_r9_valid_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    (!spk_valid_o || spk_en_o) && (!hpl_valid_o || hpl_en_o) && (!hpr_valid_o || hpr_en_o));

  // R8: nothing moves without a strobe
  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> $stable(spk_o) && $stable(hpl_o) && $stable(hpr_o)
                  && $stable(spk_en_o) && $stable(hpl_en_o) && $stable(hpr_en_o));

  // R10: disabled outputs are silent
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (spk_en_o || spk_o == '0) && (hpl_en_o || hpl_o == '0) && (hpr_en_o || hpr_o == '0));

  // R2 and R6: powerdown, standby and reserved codes switch every path off
  a_r6_quiet_modes: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && quiet_mode |=> !spk_en_o && !hpl_en_o && !hpr_en_o);
endmodule

bind audio_route_mixer route_mixer_checker #(.SAMPLE_W(SAMPLE_W), .MODE_W(MODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .strobe_i   (strobe_i),
  .spk_o      (spk_o),
  .spk_valid_o(spk_valid_o),
  .spk_en_o   (spk_en_o),
  .hpl_o      (hpl_o),
  .hpl_valid_o(hpl_valid_o),
  .hpl_en_o   (hpl_en_o),
  .hpr_o      (hpr_o),
  .hpr_valid_o(hpr_valid_o),
  .hpr_en_o   (hpr_en_o)
);

// File: tb/tb_audio_route_mixer.sv
module tb_audio_route_mixer;
  logic              clk;
  logic              rst_n;
  logic [3:0]        mode_i;
  logic              strobe_i;
  logic signed [15:0] voice_i, left_i, right_i;
  logic signed [15:0] spk_o, hpl_o, hpr_o;
  logic spk_valid_o, spk_en_o, hpl_valid_o, hpl_en_o, hpr_valid_o, hpr_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  audio_route_mixer dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .strobe_i(strobe_i),
    .voice_i(voice_i), .left_i(left_i), .right_i(right_i),
    .spk_o(spk_o), .spk_valid_o(spk_valid_o), .spk_en_o(spk_en_o),
    .hpl_o(hpl_o), .hpl_valid_o(hpl_valid_o), .hpl_en_o(hpl_en_o),
    .hpr_o(hpr_o), .hpr_valid_o(hpr_valid_o), .hpr_en_o(hpr_en_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // source codes: 0 none, 1 voice, 2 left, 3 right, 4 left+right, 5 voice+left
  function automatic int exp_src(input int mode, input int outp);
    int s [3];
    s = '{0, 0, 0};
    case (mode)
      2: s = '{1, 0, 0};
      3: s = '{0, 1, 1};
      4: s = '{1, 1, 1};
      5: s = '{4, 0, 0};
      6: s = '{0, 2, 3};
      7: s = '{4, 2, 3};
      8: s = '{2, 1, 1};
      9: s = '{5, 1, 1};
      10: s = '{1, 2, 2};
      default: s = '{0, 0, 0};
    endcase
    return s[outp];
  endfunction

  function automatic int clamp(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int exp_val(input int src, input int v, input int l, input int r);
    case (src)
      1: return v;
      2: return l;
      3: return r;
      4: return clamp(l + r);
      5: return clamp(v + l);
      default: return 0;
    endcase
  endfunction

  task automatic strobe_once(input int mode, input int v, input int l, input int r);
    @(negedge clk);
    mode_i = 4'(mode); voice_i = 16'(v); left_i = 16'(l); right_i = 16'(r);
    strobe_i = 1'b1;
    @(negedge clk);
    strobe_i = 1'b0;
  endtask

  task automatic check_outputs(input string req, input int mode, input int v, input int l, input int r,
                               input bit expect_valid);
    int s0, s1, s2;
    s0 = exp_src(mode, 0); s1 = exp_src(mode, 1); s2 = exp_src(mode, 2);
    chk(req, "spk sample", int'(spk_o), exp_val(s0, v, l, r));
    chk(req, "hpl sample", int'(hpl_o), exp_val(s1, v, l, r));
    chk(req, "hpr sample", int'(hpr_o), exp_val(s2, v, l, r));
    chk(req, "spk en", int'(spk_en_o), int'(s0 != 0));
    chk(req, "hpl en", int'(hpl_en_o), int'(s1 != 0));
    chk(req, "hpr en", int'(hpr_en_o), int'(s2 != 0));
    chk(req, "spk valid", int'(spk_valid_o), int'(expect_valid && s0 != 0));
    chk(req, "hpl valid", int'(hpl_valid_o), int'(expect_valid && s1 != 0));
    chk(req, "hpr valid", int'(hpr_valid_o), int'(expect_valid && s2 != 0));
  endtask

  function automatic string req_of(input int mode);
    if (mode <= 1) return "R2";
    if (mode <= 4) return "R3";
    if (mode <= 7) return "R4";
    if (mode <= 10) return "R5";
    return "R6";
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; strobe_i = 1'b0; mode_i = 4'd4;
    voice_i = 16'sd100; left_i = 16'sd200; right_i = 16'sd300;
    repeat (3) @(negedge clk);
    check_outputs("R1", 0, 0, 0, 0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outputs("R1", 0, 0, 0, 0, 1'b0);
  endtask

  task automatic t_mode_sweep();
    for (int m = 0; m < 16; m++) begin
      int v, l, r;
      v = 1000 + m; l = -2000 - m; r = 3000 + 7 * m;
      strobe_once(m, v, l, r);
      check_outputs(req_of(m), m, v, l, r, 1'b1);
      // R10: silent outputs stay zero with enable low
      chk("R10", "spk zero when idle", int'(spk_en_o || spk_o == 0), 1);
    end
  endtask

  task automatic t_saturation();
    strobe_once(5, 0, 30000, 30000);
    chk("R7", "lr positive clamp", int'(spk_o), 32767);
    strobe_once(5, 0, -30000, -30000);
    chk("R7", "lr negative clamp", int'(spk_o), -32768);
    strobe_once(5, 0, 32767, -32768);
    chk("R7", "lr no clamp", int'(spk_o), -1);
    strobe_once(9, 20000, 20000, 0);
    chk("R7", "vl positive clamp", int'(spk_o), 32767);
    strobe_once(9, -32768, -1, 0);
    chk("R7", "vl negative clamp", int'(spk_o), -32768);
    strobe_once(9, 16383, 16384, 0);
    chk("R7", "vl exact max", int'(spk_o), 32767);
  endtask

  task automatic t_mode_change_between();
    strobe_once(4, 1234, 555, 777);
    @(negedge clk);
    mode_i = 4'd6; voice_i = 16'sd9; left_i = 16'sd8; right_i = 16'sd7;
    repeat (3) @(negedge clk);
    check_outputs("R8", 4, 1234, 555, 777, 1'b0);
    strobe_once(6, 11, 22, 33);
    check_outputs("R8", 6, 11, 22, 33, 1'b1);
    strobe_once(0, 11, 22, 33);
    check_outputs("R8", 0, 11, 22, 33, 1'b1);
  endtask

  task automatic t_valid_pulse();
    strobe_once(7, 10, -20, 30);
    check_outputs("R9", 7, 10, -20, 30, 1'b1);
    @(negedge clk);
    check_outputs("R9", 7, 10, -20, 30, 1'b0);
  endtask

  initial begin
    t_reset();
    t_mode_sweep();
    t_saturation();
    t_mode_change_between();
    t_valid_pulse();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule